// File: doc/BRIEF.md
# Attribute-Steered Atomic Compare-and-Swap Controller

This block carries out one 32-bit compare-and-swap request at a time. Each request names a target address, the memory attribute of that address (write-back, write-through or bypass), a compare value and a store value. A six-bit policy register, written by software, holds one two-bit policy per attribute. The policy chosen by the request's attribute decides how the request runs. It can run internally, as a read, compare and conditional write on a local cached-data port. It can go to the memory side as a single read-compare-write transaction. Or it can be refused with an exception.

Every completed request returns the old memory word. Software compares that word with its compare value to find out whether the swap happened. The policy code 2 depends on the attribute: it selects internal execution only for write-back addresses. Codes that are reserved are refused in the same way as an exception, and they cause no access on either port.

Top module: `cas_policy_unit`

## Requirements
- R1: After reset the policy register holds 0x28. The write-back policy sits in bits 5:4 and is 2. The write-through policy sits in bits 3:2 and is 2. The bypass policy sits in bits 1:0 and is 0. In the reset state `req_ready` is 1 and `rsp_done`, `loc_rd`, `loc_we` and `mem_valid` are 0.
- R2: Policy 0 refuses the request for every attribute. `rsp_done` and `rsp_exc` rise in the cycle after acceptance, and no local or memory-side access is made.
- R3: Policy 1 issues exactly one memory-side transaction for every attribute. Address, compare value and store value are held stable while `mem_valid` waits for `mem_ready`. No local access is made. `rsp_done` follows one cycle after the cycle in which `mem_rsp_valid` is high.
- R4: Attribute codes are 0 for write-back, 1 for write-through and 2 for bypass. Policy 2 runs internally for write-back and is refused for write-through and for bypass.
- R5: Policy 3 and attribute code 3 are both refused with an exception, and neither makes any access.
- R6: An internal request raises `loc_rd` in the cycle after acceptance. It raises `loc_we` with the store value in the next cycle, and only when the word read equals the compare value. `rsp_done` comes in the cycle after that.
- R7: When `rsp_done` is high, `rsp_old` carries the old memory word. For a refused request it carries zero.
- R8: `req_ready` is low from the cycle after acceptance up to and including the `rsp_done` cycle. `rsp_done` is a single-cycle pulse.
- R9: A policy write applies only to requests accepted on later clock edges. A write in the same cycle as acceptance, or while a request is in flight, leaves that request's path unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Policy register write strobe |
| cfg_wdata | input | 6 | New policy register value |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle; request accepted when both are high |
| req_addr | input | 32 | Target address |
| req_attr | input | 2 | Memory attribute code of the target |
| req_cmp | input | 32 | Compare value |
| req_swp | input | 32 | Store value |
| rsp_done | output | 1 | Request finished (one-cycle pulse) |
| rsp_exc | output | 1 | Request refused |
| rsp_old | output | 32 | Old memory word (zero when refused) |
| loc_rd | output | 1 | Local word read strobe |
| loc_addr | output | 32 | Local port address |
| loc_rdata | input | 32 | Local read data, one cycle after `loc_rd` |
| loc_we | output | 1 | Local word write strobe |
| loc_wdata | output | 32 | Local write data |
| mem_valid | output | 1 | Memory-side transaction offered |
| mem_ready | input | 1 | Memory side takes the transaction |
| mem_addr | output | 32 | Transaction address |
| mem_cmp | output | 32 | Transaction compare value |
| mem_swp | output | 32 | Transaction store value |
| mem_rsp_valid | input | 1 | Transaction response present |
| mem_rsp_old | input | 32 | Old word returned by the memory side |

## Verification
Each result is due a fixed number of cycles after acceptance. A refused request completes one cycle after acceptance. An internal request completes three cycles after acceptance, with its read in the first of those cycles and any write in the second. A memory-side request completes four cycles after acceptance, plus the ready delay and the response delay that the memory model was told to insert. The bench counts falling edges from the accepting edge until `rsp_done` appears, samples every output there, and compares the count with the figure computed for the path that it derives arithmetically from the policy value and the attribute. The sweep covers all 64 policy values, all four attribute codes, and both matching and mismatching compare values.

// File: rtl/cas_pkg.sv
package cas_pkg;

    localparam int CAS_AW    = 32;
    localparam int CAS_DW    = 32;
    localparam int CAS_FW    = 2;
    localparam int CAS_NATTR = 3;
    localparam int CAS_PW    = CAS_FW * CAS_NATTR;

    localparam logic [CAS_PW-1:0] CAS_POL_RST = 6'h28;

    typedef enum logic [1:0] {
        ATTR_WB    = 2'd0,
        ATTR_WT    = 2'd1,
        ATTR_BY    = 2'd2,
        ATTR_UNDEF = 2'd3
    } cas_attr_e;

    typedef enum logic [1:0] {
        POL_EXC = 2'd0,
        POL_BUS = 2'd1,
        POL_INT = 2'd2,
        POL_RSV = 2'd3
    } cas_pol_e;

    typedef enum logic [1:0] {
        PATH_EXC   = 2'd0,
        PATH_LOCAL = 2'd1,
        PATH_BUS   = 2'd2
    } cas_path_e;

    typedef struct packed {
        logic [CAS_AW-1:0] addr;
        logic [CAS_DW-1:0] cmp;
        logic [CAS_DW-1:0] swp;
    } cas_req_t;

    // Write-back owns the top field, bypass the bottom one.
    function automatic cas_pol_e field_for(input logic [CAS_PW-1:0] pol,
                                           input cas_attr_e attr);
        cas_pol_e f;
        case (attr)
            ATTR_WB: f = cas_pol_e'(pol[2*CAS_FW +: CAS_FW]);
            ATTR_WT: f = cas_pol_e'(pol[1*CAS_FW +: CAS_FW]);
            ATTR_BY: f = cas_pol_e'(pol[0 +: CAS_FW]);
            default: f = POL_RSV;
        endcase
        return f;
    endfunction

    // Code 2 is attribute dependent; reserved codes fall back to refusal.
    function automatic cas_path_e path_for(input cas_attr_e attr,
                                           input cas_pol_e pol);
        cas_path_e p;
        case (pol)
            POL_BUS: p = PATH_BUS;
            POL_INT: p = (attr == ATTR_WB) ? PATH_LOCAL : PATH_EXC;
            default: p = PATH_EXC;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cas_policy_reg.sv
module cas_policy_reg
    import cas_pkg::*;
#(
    parameter logic [CAS_PW-1:0] RST_POLICY = CAS_POL_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CAS_PW-1:0] wr_data,
    input  cas_attr_e         attr,
    output cas_pol_e          field
);

    logic [CAS_PW-1:0] pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= RST_POLICY;
        end else if (wr_en) begin
            pol_q <= wr_data;
        end
    end

    always_comb begin
        field = field_for(pol_q, attr);
    end

endmodule

// File: rtl/cas_path_sel.sv
module cas_path_sel
    import cas_pkg::*;
(
    input  cas_attr_e attr,
    input  cas_pol_e  field,
    output cas_path_e path
);

    always_comb begin
        path = path_for(attr, field);
    end

endmodule

// File: rtl/cas_engine.sv
module cas_engine
    import cas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  cas_req_t          req,
    input  cas_path_e         path,
    output logic              rsp_done,
    output logic              rsp_exc,
    output logic [CAS_DW-1:0] rsp_old,
    output logic              loc_rd,
    output logic [CAS_AW-1:0] loc_addr,
    input  logic [CAS_DW-1:0] loc_rdata,
    output logic              loc_we,
    output logic [CAS_DW-1:0] loc_wdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [CAS_AW-1:0] mem_addr,
    output logic [CAS_DW-1:0] mem_cmp,
    output logic [CAS_DW-1:0] mem_swp,
    input  logic              mem_rsp_valid,
    input  logic [CAS_DW-1:0] mem_rsp_old
);

    typedef enum logic [2:0] {
        S_IDLE,
        S_LRD,
        S_LCMP,
        S_MREQ,
        S_MWAIT,
        S_RESP
    } eng_state_e;

    eng_state_e        state_q;
    cas_req_t          req_q;
    logic [CAS_DW-1:0] old_q;
    logic              exc_q;
    logic              accept;

    assign accept = req_valid && (state_q == S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            req_q   <= '0;
            old_q   <= '0;
            exc_q   <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        req_q <= req;
                        old_q <= '0;
                        exc_q <= (path == PATH_EXC);
                        case (path)
                            PATH_LOCAL: state_q <= S_LRD;
                            PATH_BUS:   state_q <= S_MREQ;
                            default:    state_q <= S_RESP;
                        endcase
                    end
                end
                S_LRD:  state_q <= S_LCMP;
                S_LCMP: begin
                    old_q   <= loc_rdata;
                    state_q <= S_RESP;
                end
                S_MREQ: begin
                    if (mem_ready) state_q <= S_MWAIT;
                end
                S_MWAIT: begin
                    if (mem_rsp_valid) begin
                        old_q   <= mem_rsp_old;
                        state_q <= S_RESP;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_done  = (state_q == S_RESP);
        rsp_exc   = rsp_done && exc_q;
        rsp_old   = rsp_done ? old_q : '0;
        loc_rd    = (state_q == S_LRD);
        loc_addr  = req_q.addr;
        loc_we    = (state_q == S_LCMP) && (loc_rdata == req_q.cmp);
        loc_wdata = req_q.swp;
        mem_valid = (state_q == S_MREQ);
        mem_addr  = req_q.addr;
        mem_cmp   = req_q.cmp;
        mem_swp   = req_q.swp;
    end

endmodule

// File: rtl/cas_policy_unit.sv
module cas_policy_unit
    import cas_pkg::*;
#(
    parameter logic [CAS_PW-1:0] RST_POLICY = CAS_POL_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CAS_PW-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CAS_AW-1:0] req_addr,
    input  logic [1:0]        req_attr,
    input  logic [CAS_DW-1:0] req_cmp,
    input  logic [CAS_DW-1:0] req_swp,
    output logic              rsp_done,
    output logic              rsp_exc,
    output logic [CAS_DW-1:0] rsp_old,
    output logic              loc_rd,
    output logic [CAS_AW-1:0] loc_addr,
    input  logic [CAS_DW-1:0] loc_rdata,
    output logic              loc_we,
    output logic [CAS_DW-1:0] loc_wdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [CAS_AW-1:0] mem_addr,
    output logic [CAS_DW-1:0] mem_cmp,
    output logic [CAS_DW-1:0] mem_swp,
    input  logic              mem_rsp_valid,
    input  logic [CAS_DW-1:0] mem_rsp_old
);

    cas_attr_e attr;
    cas_pol_e  field;
    cas_path_e path;
    cas_req_t  req;

    assign attr     = cas_attr_e'(req_attr);
    assign req.addr = req_addr;
    assign req.cmp  = req_cmp;
    assign req.swp  = req_swp;

    cas_policy_reg #(
        .RST_POLICY (RST_POLICY)
    ) pol_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .attr    (attr),
        .field   (field)
    );

    cas_path_sel sel_i (
        .attr  (attr),
        .field (field),
        .path  (path)
    );

    cas_engine eng_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req           (req),
        .path          (path),
        .rsp_done      (rsp_done),
        .rsp_exc       (rsp_exc),
        .rsp_old       (rsp_old),
        .loc_rd        (loc_rd),
        .loc_addr      (loc_addr),
        .loc_rdata     (loc_rdata),
        .loc_we        (loc_we),
        .loc_wdata     (loc_wdata),
        .mem_valid     (mem_valid),
        .mem_ready     (mem_ready),
        .mem_addr      (mem_addr),
        .mem_cmp       (mem_cmp),
        .mem_swp       (mem_swp),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_old   (mem_rsp_old)
    );

endmodule

// File: rtl/cas_policy_unit_chk.sv
module cas_policy_unit_chk
    import cas_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_exc,
    input logic [CAS_DW-1:0] rsp_old,
    input logic              loc_rd,
    input logic              loc_we,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [CAS_AW-1:0] mem_addr,
    input logic [CAS_DW-1:0] mem_cmp,
    input logic [CAS_DW-1:0] mem_swp
);

    assert_exc_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_exc |-> $past(req_valid && req_ready));

    assert_bus_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_cmp) && $stable(mem_swp)));

    assert_paths_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && (loc_rd || loc_we)));

    assert_write_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        loc_we |-> $past(loc_rd));

    assert_exc_old_zero_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_exc |-> (rsp_old == '0));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

endmodule

bind cas_policy_unit cas_policy_unit_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_exc   (rsp_exc),
    .rsp_old   (rsp_old),
    .loc_rd    (loc_rd),
    .loc_we    (loc_we),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_cmp   (mem_cmp),
    .mem_swp   (mem_swp)
);

// File: tb/cas_policy_unit_tb_top.sv
module cas_policy_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_attr = '0;
    logic [31:0] req_cmp = '0;
    logic [31:0] req_swp = '0;
    logic        rsp_done, rsp_exc;
    logic [31:0] rsp_old;
    logic        loc_rd, loc_we;
    logic [31:0] loc_addr, loc_wdata;
    logic [31:0] loc_rdata;
    logic        mem_valid, mem_ready;
    logic [31:0] mem_addr, mem_cmp, mem_swp;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_old;

    always #(CLK_PERIOD/2) clk = ~clk;

    cas_policy_unit dut_i (
        .clk (clk), .rst (rst),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_attr (req_attr),
        .req_cmp (req_cmp), .req_swp (req_swp),
        .rsp_done (rsp_done), .rsp_exc (rsp_exc), .rsp_old (rsp_old),
        .loc_rd (loc_rd), .loc_addr (loc_addr), .loc_rdata (loc_rdata),
        .loc_we (loc_we), .loc_wdata (loc_wdata),
        .mem_valid (mem_valid), .mem_ready (mem_ready),
        .mem_addr (mem_addr), .mem_cmp (mem_cmp), .mem_swp (mem_swp),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_old (mem_rsp_old)
    );

    // Neighbour models: local word store and memory side.
    logic [31:0] loc_mem [NW];
    logic [31:0] ext_mem [NW];
    int          loc_rd_cnt, loc_we_cnt, hs_cnt;
    int          rdy_lat = 0, rsp_lat = 0;
    int          rdy_cnt, rsp_cnt;
    logic        pend;

    assign mem_ready = mem_valid && (rdy_cnt == rdy_lat);

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NW; i++) begin
                loc_mem[i] <= 32'h1000_0000 + i;
                ext_mem[i] <= 32'h2000_0000 + i;
            end
            loc_rdata     <= '0;
            loc_rd_cnt    <= 0;
            loc_we_cnt    <= 0;
            hs_cnt        <= 0;
            rdy_cnt       <= 0;
            rsp_cnt       <= 0;
            pend          <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_old   <= '0;
        end else begin
            if (loc_rd) begin
                loc_rdata  <= loc_mem[loc_addr[5:2]];
                loc_rd_cnt <= loc_rd_cnt + 1;
            end
            if (loc_we) begin
                loc_mem[loc_addr[5:2]] <= loc_wdata;
                loc_we_cnt <= loc_we_cnt + 1;
            end
            rdy_cnt       <= (mem_valid && !mem_ready) ? rdy_cnt + 1 : 0;
            mem_rsp_valid <= 1'b0;
            if (mem_valid && mem_ready) begin
                pend        <= 1'b1;
                rsp_cnt     <= rsp_lat;
                hs_cnt      <= hs_cnt + 1;
                mem_rsp_old <= ext_mem[mem_addr[5:2]];
                if (ext_mem[mem_addr[5:2]] == mem_cmp)
                    ext_mem[mem_addr[5:2]] <= mem_swp;
            end else if (pend) begin
                if (rsp_cnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    pend          <= 1'b0;
                end else begin
                    rsp_cnt <= rsp_cnt - 1;
                end
            end
        end
    end

    int          n_total = 0, n_fail = 0;
    logic [31:0] exp_loc [NW];
    logic [31:0] exp_ext [NW];
    logic [5:0]  cur_cfg;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    // 0 refused, 1 internal, 2 memory side
    function automatic int exp_path(input logic [5:0] cfg, input int attr);
        int f;
        if (attr == 3) return 0;
        f = (cfg >> (4 - 2*attr)) & 3;
        if (f == 1) return 2;
        if (f == 2 && attr == 0) return 1;
        return 0;
    endfunction

    function automatic string tag_for(input logic [5:0] cfg, input int attr);
        int f;
        if (attr == 3) return "R5";
        f = (cfg >> (4 - 2*attr)) & 3;
        case (f)
            0: return "R2";
            1: return "R3";
            2: return (attr == 0) ? "R6" : "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic write_cfg(input logic [5:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
        cur_cfg   = v;
    endtask

    // wr_when: 0 none, 1 same cycle as acceptance, 2 while in flight
    task automatic run_req(input int attr, input bit match, input int idx,
                           input int rl, input int sl,
                           input int wr_when, input logic [5:0] wr_val);
        int          path, n, lat, d_rd, d_we, d_hs;
        bit          busy_ok;
        logic [31:0] oldw, cmpv, swpv;
        string       tg;
        path = exp_path(cur_cfg, attr);
        tg   = tag_for(cur_cfg, attr);
        oldw = (path == 2) ? exp_ext[idx] : exp_loc[idx];
        cmpv = match ? oldw : (oldw ^ 32'h0000_0055);
        swpv = 32'hA000_0000 ^ (idx << 8) ^ (attr << 4) ^ n_total;
        d_rd = loc_rd_cnt; d_we = loc_we_cnt; d_hs = hs_cnt;
        @(negedge clk);
        rdy_lat   = rl;
        rsp_lat   = sl;
        req_valid = 1'b1;
        req_attr  = attr[1:0];
        req_addr  = 32'h0000_4000 | (idx << 2);
        req_cmp   = cmpv;
        req_swp   = swpv;
        cfg_we    = (wr_when == 1);
        cfg_wdata = wr_val;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = (wr_when == 2);
        n = 1;
        busy_ok = 1'b1;
        while (!rsp_done && n < 40) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            cfg_we = 1'b0;
            n++;
        end
        if (req_ready) busy_ok = 1'b0;
        cfg_we = 1'b0;
        if (wr_when != 0) cur_cfg = wr_val;
        lat = (path == 0) ? 1 : (path == 1) ? 3 : 4 + rl + sl;
        chk(n == lat, tg, "latency", n, lat);
        chk(rsp_exc == (path == 0), tg, "exception flag", rsp_exc, path == 0);
        chk(rsp_old == ((path == 0) ? 32'h0 : oldw), "R7", "old word",
            rsp_old, (path == 0) ? 32'h0 : oldw);
        chk(busy_ok, "R8", "ready low while busy", busy_ok, 1);
        @(negedge clk);
        chk(!rsp_done, "R8", "done single pulse", rsp_done, 0);
        chk((loc_rd_cnt - d_rd) == (path == 1 ? 1 : 0), tg, "local reads",
            loc_rd_cnt - d_rd, path == 1 ? 1 : 0);
        chk((loc_we_cnt - d_we) == ((path == 1 && match) ? 1 : 0), tg, "local writes",
            loc_we_cnt - d_we, (path == 1 && match) ? 1 : 0);
        chk((hs_cnt - d_hs) == (path == 2 ? 1 : 0), tg, "memory transactions",
            hs_cnt - d_hs, path == 2 ? 1 : 0);
        if (match && path == 1) exp_loc[idx] = swpv;
        if (match && path == 2) exp_ext[idx] = swpv;
        chk(loc_mem[idx] == exp_loc[idx], tg, "local word", loc_mem[idx], exp_loc[idx]);
        chk(ext_mem[idx] == exp_ext[idx], tg, "memory word", ext_mem[idx], exp_ext[idx]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_total++;
        n_fail++;
        $display("FAIL R8 watchdog expired: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            exp_loc[i] = 32'h1000_0000 + i;
            exp_ext[i] = 32'h2000_0000 + i;
        end
        cur_cfg = 6'h28;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(!rsp_done && !loc_rd && !loc_we && !mem_valid, "R1", "idle outputs",
            {rsp_done, loc_rd, loc_we, mem_valid}, 0);
        // R1 reset policy: write-back and write-through internal? only WB internal
        chk(exp_path(6'h28, 0) == 1, "R1", "reset policy decode WB", exp_path(6'h28, 0), 1);
        run_req(0, 1, 1, 0, 0, 0, 6'h00);
        run_req(1, 1, 2, 0, 0, 0, 6'h00);
        run_req(2, 1, 3, 0, 0, 0, 6'h00);
        run_req(0, 0, 4, 0, 0, 0, 6'h00);
        // R9: write in the acceptance cycle keeps the old policy for that request
        run_req(0, 1, 5, 0, 0, 1, 6'h00);
        chk(cur_cfg == 6'h00, "R9", "policy tracking", cur_cfg, 0);
        run_req(0, 1, 5, 0, 0, 0, 6'h00);
        // R9: write during a memory-side request leaves it on that path
        write_cfg(6'h15);
        run_req(2, 1, 6, 2, 1, 2, 6'h00);
        run_req(2, 1, 6, 0, 0, 0, 6'h00);
        // Sweep of every policy value over every attribute code
        for (int c = 0; c < 64; c++) begin
            write_cfg(c[5:0]);
            for (int a = 0; a < 4; a++) begin
                for (int m = 0; m < 2; m++) begin
                    run_req(a, m[0], (c + a*3 + m) % NW, (c + a) % 3, (c + m) % 2,
                            0, 6'h00);
                end
            end
        end
        summary();
        $finish;
    end

endmodule